// File: doc/BRIEF.md
# Triggered Zero-Suppressed Pixel Matrix Readout

This block is the digital side of one region of a pixel matrix. Every pixel holds a one-bit hit flag. A trigger opens a strobe window of programmable length. In every cycle of that window, each pixel ORs its discriminator bit into its flag, so all pixels capture together. Outside the window the discriminator bits have no effect.

Once the window closes, a priority encoder in each column picks the lowest-row pixel that holds a hit. A drain controller walks the columns in ascending order. It presents one address per clock on a valid/address stream and empties each column before it moves to the next one. When the periphery accepts an address with read-enable, it resets that pixel, and the next hit in the column is presented in the following cycle. After the last column has been scanned, a one-cycle end-of-frame pulse closes the frame. An empty frame produces only that pulse.

A full region is 512 rows by 32 columns. The default parameters elaborate a reduced 64 by 8 matrix. The address widths are derived from the row and column counts.

Top module: `pix_sparse_readout`

## Requirements
- R1: After reset, valid_o and eof_o are low and no address is presented until a trigger has been accepted.
- R2: A pixel is reported when its discriminator bit (index col*NUM_ROWS+row of disc_i) is high at one or more edges of the strobe window. The window is the trigger edge plus the max(strobe_len_i,1)-1 edges that follow it.
- R3: Discriminator bits that are high only before the trigger, or only after the window has closed, produce no address.
- R4: Only pixels that hold a hit are reported, and each of them is reported exactly once per frame.
- R5: addr_o is {column, row}, with the column in the upper COL_W bits. Addresses leave in ascending column order and, within a column, in ascending row order, so the lowest row has priority.
- R6: While valid_o is high and rd_en_i is high at an edge, that pixel is reset and the next hit (if any) is presented in the following cycle. While rd_en_i is low, valid_o and addr_o hold.
- R7: eof_o pulses high for exactly one cycle after the last column has been scanned, with valid_o low in that cycle. In a frame with no hits, the pulse is the only output.
- R8: A trigger seen during the strobe window, during the drain or in the end-of-frame cycle starts no new frame. No second eof_o pulse appears without a new accepted trigger.
- R9: strobe_len_i of 0 behaves as 1, so only the trigger edge captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| disc_i | input | NUM_ROWS*NUM_COLS | Discriminator bits, index col*NUM_ROWS+row |
| trig_i | input | 1 | Trigger; accepted only when idle |
| strobe_len_i | input | LEN_W | Strobe window length in cycles, sampled with the trigger |
| rd_en_i | input | 1 | Accept the presented address and reset that pixel |
| valid_o | output | 1 | Address on addr_o is valid |
| addr_o | output | COL_W+ROW_W | Hit address {column, row} |
| eof_o | output | 1 | End-of-frame pulse |

## Verification
Capture is due at the trigger edge and at each of the max(len,1)-1 edges after it. The bench drives the inputs on falling edges and ORs exactly those cycles' bits into its reference map. The first address can appear in the cycle after the last window edge. After each accepted address, the next one is due one cycle later, and the bench samples just after every falling edge. It checks stalls by requiring the same address in the next sample. It expects eof_o after the remaining columns have been scanned, one cycle per empty column, and it compares the collected list with a column-then-row walk of the reference map.

// File: rtl/pix_sparse_pkg.sv
package pix_sparse_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STROBE = 2'd1,
    ST_DRAIN  = 2'd2,
    ST_EOF    = 2'd3
  } rd_state_e;
endpackage

// File: rtl/pix_col_prio_enc.sv
module pix_col_prio_enc #(
  parameter int NUM_ROWS = 64,
  localparam int ROW_W = $clog2(NUM_ROWS)
) (
  input  logic [NUM_ROWS-1:0] hits_i,
  output logic                any_o,
  output logic [ROW_W-1:0]    row_o
);
  // lowest set index wins
  always_comb begin
    row_o = '0;
    for (int i = NUM_ROWS - 1; i >= 0; i--) begin
      if (hits_i[i]) row_o = ROW_W'(i);
    end
  end
  assign any_o = |hits_i;
endmodule

// File: rtl/pix_hit_matrix.sv
module pix_hit_matrix #(
  parameter int NUM_ROWS = 64,
  parameter int NUM_COLS = 8,
  localparam int ROW_W = $clog2(NUM_ROWS),
  localparam int COL_W = $clog2(NUM_COLS),
  localparam int NPIX  = NUM_ROWS * NUM_COLS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPIX-1:0]  disc_i,
  input  logic             capture_i,
  input  logic             clr_en_i,
  input  logic [COL_W-1:0] clr_col_i,
  input  logic [ROW_W-1:0] clr_row_i,
  output logic [NUM_COLS-1:0] col_any_o,
  output logic [ROW_W-1:0] col_row_o [NUM_COLS]
);
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    logic [NUM_ROWS-1:0] mem_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q <= '0;
      end else if (capture_i) begin
        mem_q <= mem_q | disc_i[c*NUM_ROWS +: NUM_ROWS];
      end else if (clr_en_i && clr_col_i == COL_W'(c)) begin
        mem_q[clr_row_i] <= 1'b0;
      end
    end

    pix_col_prio_enc #(.NUM_ROWS(NUM_ROWS)) u_enc (
      .hits_i (mem_q),
      .any_o  (col_any_o[c]),
      .row_o  (col_row_o[c])
    );
  end
endmodule

// File: rtl/pix_readout_ctrl.sv
module pix_readout_ctrl
  import pix_sparse_pkg::*;
#(
  parameter int NUM_ROWS = 64,
  parameter int NUM_COLS = 8,
  parameter int LEN_W    = 8,
  localparam int ROW_W = $clog2(NUM_ROWS),
  localparam int COL_W = $clog2(NUM_COLS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                trig_i,
  input  logic [LEN_W-1:0]    strobe_len_i,
  input  logic                rd_en_i,
  input  logic [NUM_COLS-1:0] col_any_i,
  input  logic [ROW_W-1:0]    col_row_i [NUM_COLS],
  output logic                capture_o,
  output logic                clr_en_o,
  output logic [COL_W-1:0]    clr_col_o,
  output logic [ROW_W-1:0]    clr_row_o,
  output logic                valid_o,
  output logic [COL_W+ROW_W-1:0] addr_o,
  output logic                eof_o
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

  rd_state_e        state_q;
  logic [LEN_W-1:0] cnt_q;
  logic [COL_W-1:0] col_q;
  logic             cur_any;
  logic [ROW_W-1:0] cur_row;

  assign cur_any = col_any_i[col_q];
  assign cur_row = col_row_i[col_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      col_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (trig_i) begin
          if (strobe_len_i <= LEN_W'(1)) begin
            state_q <= ST_DRAIN;
          end else begin
            cnt_q   <= strobe_len_i - LEN_W'(1);
            state_q <= ST_STROBE;
          end
        end
        ST_STROBE: begin
          cnt_q <= cnt_q - LEN_W'(1);
          if (cnt_q == LEN_W'(1)) state_q <= ST_DRAIN;
        end
        ST_DRAIN: if (!cur_any) begin
          if (col_q == LAST_COL) begin
            col_q   <= '0;
            state_q <= ST_EOF;
          end else begin
            col_q <= col_q + COL_W'(1);
          end
        end
        ST_EOF: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign capture_o = (state_q == ST_IDLE && trig_i) || state_q == ST_STROBE;
  assign valid_o   = state_q == ST_DRAIN && cur_any;
  assign addr_o    = {col_q, cur_row};
  assign eof_o     = state_q == ST_EOF;
  assign clr_en_o  = valid_o && rd_en_i;
  assign clr_col_o = col_q;
  assign clr_row_o = cur_row;
endmodule

// File: rtl/pix_sparse_readout.sv
module pix_sparse_readout #(
  parameter int NUM_ROWS = 64,
  parameter int NUM_COLS = 8,
  parameter int LEN_W    = 8,
  localparam int ROW_W  = $clog2(NUM_ROWS),
  localparam int COL_W  = $clog2(NUM_COLS),
  localparam int ADDR_W = COL_W + ROW_W,
  localparam int NPIX   = NUM_ROWS * NUM_COLS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPIX-1:0]   disc_i,
  input  logic              trig_i,
  input  logic [LEN_W-1:0]  strobe_len_i,
  input  logic              rd_en_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              eof_o
);
  logic                capture;
  logic                clr_en;
  logic [COL_W-1:0]    clr_col;
  logic [ROW_W-1:0]    clr_row;
  logic [NUM_COLS-1:0] col_any;
  logic [ROW_W-1:0]    col_row [NUM_COLS];

  pix_hit_matrix #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)) u_matrix (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .disc_i    (disc_i),
    .capture_i (capture),
    .clr_en_i  (clr_en),
    .clr_col_i (clr_col),
    .clr_row_i (clr_row),
    .col_any_o (col_any),
    .col_row_o (col_row)
  );

  pix_readout_ctrl #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .LEN_W(LEN_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .trig_i       (trig_i),
    .strobe_len_i (strobe_len_i),
    .rd_en_i      (rd_en_i),
    .col_any_i    (col_any),
    .col_row_i    (col_row),
    .capture_o    (capture),
    .clr_en_o     (clr_en),
    .clr_col_o    (clr_col),
    .clr_row_o    (clr_row),
    .valid_o      (valid_o),
    .addr_o       (addr_o),
    .eof_o        (eof_o)
  );
endmodule

// File: rtl/pix_sparse_readout_chk.sv
module pix_sparse_readout_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_en_i,
  input logic              valid_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              eof_o
);
  a_r6_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !rd_en_i |=> valid_o && $stable(addr_o));

  a_r5_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && rd_en_i |=> !valid_o || addr_o > $past(addr_o));

  a_r7_eof_excl_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> !valid_o);

  a_r7_eof_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |=> !eof_o);

  a_r8_no_valid_after_eof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |=> !valid_o);
endmodule

bind pix_sparse_readout pix_sparse_readout_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .rd_en_i (rd_en_i),
  .valid_o (valid_o),
  .addr_o  (addr_o),
  .eof_o   (eof_o)
);

// File: tb/pix_sparse_readout_tb.sv
module pix_sparse_readout_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_ROWS = 64;
  localparam int NUM_COLS = 8;
  localparam int LEN_W = 8;
  localparam int ROW_W = $clog2(NUM_ROWS);
  localparam int COL_W = $clog2(NUM_COLS);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int NPIX = NUM_ROWS * NUM_COLS;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NPIX-1:0] disc = '0;
  logic trig = 1'b0;
  logic [LEN_W-1:0] slen = '0;
  logic rd_en = 1'b0;
  logic valid;
  logic [ADDR_W-1:0] addr;
  logic eof;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [NPIX-1:0] exp_map;
  int got [NPIX+1];
  int n_got;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_sparse_readout #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .LEN_W(LEN_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .disc_i(disc), .trig_i(trig),
    .strobe_len_i(slen), .rd_en_i(rd_en), .valid_o(valid), .addr_o(addr), .eof_o(eof)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [NPIX-1:0] gen_disc(input int shift);
    logic [NPIX-1:0] d = '0;
    for (int i = 0; i < NPIX; i++) if (($urandom() >> shift) % 64 == 0) d[i] = 1'b1;
    return d;
  endfunction

  // mode 0 random, 1 empty, 2 corners; stall: random rd_en
  task automatic run_frame(input int mode, input int len, input bit stall);
    int win;
    int idx;
    bit prev_stall;
    int prev_addr;
    bit done;
    int to;
    win = (len < 1) ? 1 : len;
    exp_map = '0;
    n_got = 0;
    // R3: activity before trigger is ignored
    @(negedge clk); disc = (mode == 1) ? '0 : gen_disc(2);
    @(negedge clk); disc = (mode == 1) ? '0 : gen_disc(3);
    @(negedge clk);
    trig = 1'b1;
    slen = LEN_W'(len);
    if (mode == 0) disc = gen_disc(1);
    else if (mode == 1) disc = '0;
    else begin
      disc = '0;
      disc[0] = 1'b1;
      disc[NUM_ROWS-1] = 1'b1;
      disc[NPIX-1] = 1'b1;
      disc[NUM_ROWS] = 1'b1;
    end
    exp_map |= disc;
    for (int w = 1; w < win; w++) begin
      @(negedge clk);
      trig = $urandom() % 2; // R8: ignored inside window
      disc = (mode == 0) ? gen_disc(4) : '0;
      exp_map |= disc;
    end
    prev_stall = 0;
    prev_addr = 0;
    done = 0;
    to = 0;
    while (!done) begin
      @(negedge clk);
      trig = ($urandom() % 4 == 0); // R8
      disc = (mode == 1) ? '0 : gen_disc(5); // R3: after window
      rd_en = stall ? ($urandom() % 2 == 1) : 1'b1;
      #1;
      if (prev_stall) check(valid && int'(addr) == prev_addr, "R6 stall hold", int'(addr), prev_addr);
      if (eof) begin
        check(!valid, "R7 eof without valid", int'(valid), 0);
        done = 1;
      end else if (valid) begin
        if (rd_en) begin
          if (n_got < NPIX) got[n_got] = int'(addr);
          n_got++;
        end
        prev_stall = !rd_en;
        prev_addr = int'(addr);
      end else begin
        prev_stall = 0;
      end
      to++;
      if (to > 5000) begin
        check(0, "R7 eof timeout", to, 0);
        done = 1;
      end
    end
    trig = 1'b0;
    rd_en = 1'b1;
    // R2 R4 R5: compare against column-then-row walk of reference map
    idx = 0;
    for (int c = 0; c < NUM_COLS; c++) begin
      for (int r = 0; r < NUM_ROWS; r++) begin
        if (exp_map[c*NUM_ROWS + r]) begin
          if (idx < n_got) check(got[idx] == ((c << ROW_W) | r), "R5 R2 address order", got[idx], (c << ROW_W) | r);
          idx++;
        end
      end
    end
    check(n_got == idx, "R4 hit count", n_got, idx);
    // R8: no frame without a new accepted trigger
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      disc = gen_disc(2);
      #1;
      check(!valid && !eof, "R8 idle after frame", int'(valid) + int'(eof), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rd_en = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(!valid && !eof, "R1 reset outputs", int'(valid) + int'(eof), 0);
    rst_ni = 1'b1;
    @(negedge clk); #1;
    check(!valid && !eof, "R1 idle after reset", int'(valid) + int'(eof), 0);
    run_frame(1, 3, 0);   // R7: empty frame
    check(n_got == 0, "R7 empty frame no data", n_got, 0);
    run_frame(2, 1, 0);   // R5 corner rows/cols
    check(n_got == 4, "R5 corner count", n_got, 4);
    run_frame(0, 0, 0);   // R9: zero length acts as one
    run_frame(0, 1, 1);
    for (int f = 0; f < 8; f++) run_frame(0, 1 + ($urandom() % 6), f % 2 == 1);
    run_frame(2, 5, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule